// File: doc/BRIEF.md
# General-Purpose Pad Controller with Event Routing

This block owns a small group of general-purpose pads. For each pad it holds two 32-bit configuration words. From these it drives the pad's output value and output enable, or hands both to a native function. It samples the pad input through a two-flop synchroniser, optionally inverts it, and detects a level or an edge. Detected events are held in a per-pad status word. The block then routes them to four interrupt outputs: non-maskable, system-management, system-control and interrupt-controller.

A standby input forces each pad into a pin state programmed in the second word. That state sets the drive, sets whether the receiver is in use, and can substitute a fixed value for the input seen by the core. The same field also asks for a termination override. Four active-low reset inputs model separate reset domains. Each pad chooses which domain returns its configuration to defaults. Software reaches the words and the status word through a plain single-cycle register port:
- write: `reg_wr` with `reg_addr`/`reg_wdata`, taking effect at the clock edge;
- read: combinational on `reg_rdata` from `reg_addr`.

Address 2p is pad p's word 0, 2p+1 is its word 1, and 2·NPADS is the status word.

Top module: `gpio_pic`

## Requirements
- R1: After reset, word 0 of every pad reads 0x04000100 plus bit 1. Word 1 reads 0x0003C000 and the status word reads 0. Only word-0 bits 0, 8, 9, 12:10, 20:17, 23, 26:25, 31:30 and word-1 bits 9:8, 17:14 are writable; all other bits read 0. Word-0 bit 1 is read-only and shows the input value the core sees.
- R2: In mode 0 (word 0 bits 12:10 = 0), `pad_out` follows word-0 bit 0 and `pad_oe` is the inverse of bit 8.
- R3: Modes 1 to 6 pass `nf_out`/`nf_oe` of that pad straight to `pad_out`/`pad_oe`. Mode 7 behaves as mode 0.
- R4: With word-0 bit 9 set and no standby feed active, `core_in` is 0 and the pad produces no level or edge event, regardless of bit 23.
- R5: The input passes two flops before detection. The sensed value is the synchronised input XOR word-0 bit 23. In trigger code 0 (bits 26:25) the pad's status bit shows the live sensed value.
- R6: Trigger code 1 latches the status bit on a 0-to-1 change of the sensed value. With bit 23 set, this is a falling edge of the raw pin.
- R7: Trigger code 3 latches on either change; trigger code 2 keeps the status bit at 0.
- R8: Writing the status word clears each latched bit whose written bit is 1 and leaves the others.
- R9: Interrupt output k (bit 17+k of word 0: NMI, SMI, SCI, interrupt controller) is a register holding the OR over pads of status AND route bit k. It lags the status by one clock.
- R10: When `standby` is high and word-1 bits 17:14 hold 0 to 9, the drive is as follows:
  - 0: last normal drive;
  - 1 to 4: drive 0,0,1,1 and feed 0,1,0,1 to the core;
  - 5 and 6: drive 0 and 1, receiver kept;
  - 7 and 8: high-Z, feeding 0 and 1;
  - 9: high-Z, receiver kept.

  Codes 10 to 15 have no effect.
- R11: While a standby code 0 to 9 is in force, word-1 bits 9:8 drive the termination outputs. Code 0 gives no force. Code 1 forces with neither pull. Code 2 forces pull-down and code 3 forces pull-up.
- R12: A pad whose word-0 bits 31:30 select domain d (0 power-good, 1 deep, 2 platform, 3 resume) returns both words to defaults while that domain's reset is low. Other pads keep their words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pwrok_n | input | 1 | Power-good reset, active low; resets all state |
| rst_deep_n | input | 1 | Deep reset domain, active low |
| rst_plt_n | input | 1 | Platform reset domain, active low |
| rst_rsm_n | input | 1 | Resume reset domain, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| standby | input | 1 | Standby request |
| pad_in | input | NPADS | Pad input levels |
| pad_out | output | NPADS | Pad output values |
| pad_oe | output | NPADS | Pad output enables |
| nf_out | input | NPADS | Native-function output values |
| nf_oe | input | NPADS | Native-function output enables |
| core_in | output | NPADS | Input value delivered to the core |
| term_force | output | NPADS | Termination override active |
| term_up | output | NPADS | Override requests pull-up |
| term_dn | output | NPADS | Override requests pull-down |
| irq_nmi | output | 1 | Routed non-maskable interrupt |
| irq_smi | output | 1 | Routed system-management interrupt |
| irq_sci | output | 1 | Routed system-control interrupt |
| irq_apic | output | 1 | Routed interrupt-controller interrupt |

## Verification
The bench sweeps every pad through all four trigger codes with and without inversion, stepping the pin through rises and falls. A design that ignored inversion in single-edge mode would latch on the raw rising edge. One that let the off code latch would raise interrupts from a pad meant to be silent. A mid-sequence clear catches a status bit that stays set, and the route check catches a wrong output index. A full sweep of the sixteen standby codes catches a swapped drive and feed pair, and a reserved code that wrongly overrides the pad. A platform-domain reset pulse catches a design that resets every pad, or none, instead of only those that selected that domain.

// File: rtl/gpio_pic_pkg.sv
package gpio_pic_pkg;
  localparam int DW = 32;

  localparam int W0_TXVAL  = 0;
  localparam int W0_RXSEEN = 1;
  localparam int W0_TXDIS  = 8;
  localparam int W0_RXDIS  = 9;
  localparam int W0_MODE   = 10;
  localparam int W0_ROUTE  = 17;
  localparam int W0_RXINV  = 23;
  localparam int W0_TRIG   = 25;
  localparam int W0_RSEL   = 30;
  localparam int W1_TERM   = 8;
  localparam int W1_STBY   = 14;

  localparam logic [DW-1:0] W0_WMASK   = 32'hC69E_1F01;
  localparam logic [DW-1:0] W1_WMASK   = 32'h0003_C300;
  localparam logic [DW-1:0] W0_DEFAULT = 32'h0400_0100;
  localparam logic [DW-1:0] W1_DEFAULT = 32'h0003_C000;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_ONE   = 2'd1,
    TRIG_OFF   = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic       txval;
    logic       txdis;
    logic       rxdis;
    logic [2:0] mode;
    logic [3:0] route;
    logic       rxinv;
    trig_e      trig;
    logic [1:0] rsel;
    logic [1:0] term;
    logic [3:0] stby;
  } pad_cfg_t;

  function automatic pad_cfg_t decode_cfg(input logic [DW-1:0] w0, input logic [DW-1:0] w1);
    pad_cfg_t c;
    c.txval = w0[W0_TXVAL];
    c.txdis = w0[W0_TXDIS];
    c.rxdis = w0[W0_RXDIS];
    c.mode  = w0[W0_MODE +: 3];
    c.route = w0[W0_ROUTE +: 4];
    c.rxinv = w0[W0_RXINV];
    c.trig  = trig_e'(w0[W0_TRIG +: 2]);
    c.rsel  = w0[W0_RSEL +: 2];
    c.term  = w1[W1_TERM +: 2];
    c.stby  = w1[W1_STBY +: 4];
    return c;
  endfunction
endpackage

// File: rtl/gpio_pic_cfg.sv
module gpio_pic_cfg
  import gpio_pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_pwrok_n,
  input  logic [3:0]    dom_rst_n,
  input  logic          we0,
  input  logic          we1,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] w0_q,
  output logic [DW-1:0] w1_q,
  output pad_cfg_t      cfg
);
  logic dom_clr;
  assign dom_clr = !dom_rst_n[w0_q[W0_RSEL +: 2]];

  always_ff @(posedge clk or negedge rst_pwrok_n) begin
    if (!rst_pwrok_n) begin
      w0_q <= W0_DEFAULT;
      w1_q <= W1_DEFAULT;
    end else if (dom_clr) begin
      w0_q <= W0_DEFAULT;
      w1_q <= W1_DEFAULT;
    end else begin
      if (we0) w0_q <= wdata & W0_WMASK;
      if (we1) w1_q <= wdata & W1_WMASK;
    end
  end

  assign cfg = decode_cfg(w0_q, w1_q);

  a_r12_domain_reset: assert property (@(posedge clk) disable iff (!rst_pwrok_n)
    dom_clr |=> (w0_q == W0_DEFAULT && w1_q == W1_DEFAULT));
  a_r1_unwritable_zero: assert property (@(posedge clk) disable iff (!rst_pwrok_n)
    ((w0_q & ~W0_WMASK) == '0) && ((w1_q & ~W1_WMASK) == '0));
endmodule

// File: rtl/gpio_pic_pad.sv
module gpio_pic_pad
  import gpio_pic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pad_cfg_t cfg,
  input  logic     pad_in,
  input  logic     nf_out,
  input  logic     nf_oe,
  input  logic     standby,
  input  logic     sts_clr,
  output logic     pad_out,
  output logic     pad_oe,
  output logic     core_in,
  output logic     term_force,
  output logic     term_up,
  output logic     term_dn,
  output logic     sts_vis
);
  logic s1, s2, sensed, sensed_q, sts_q, set_ev, edge_mode;
  logic native, norm_out, norm_oe, last_out, last_oe;
  logic stby_act, feed_en, feed_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
    end
  end

  assign native   = (cfg.mode != 3'd0) && (cfg.mode != 3'd7);
  assign norm_out = native ? nf_out : cfg.txval;
  assign norm_oe  = native ? nf_oe  : !cfg.txdis;
  assign stby_act = standby && (cfg.stby <= 4'd9);

  always_comb begin
    pad_out  = norm_out;
    pad_oe   = norm_oe;
    feed_en  = 1'b0;
    feed_val = 1'b0;
    if (stby_act) begin
      case (cfg.stby)
        4'd0: begin pad_out = last_out; pad_oe = last_oe; end
        4'd1, 4'd2, 4'd3, 4'd4: begin
          pad_oe   = 1'b1;
          pad_out  = (cfg.stby >= 4'd3);
          feed_en  = 1'b1;
          feed_val = !cfg.stby[0];
        end
        4'd5, 4'd6: begin pad_oe = 1'b1; pad_out = (cfg.stby == 4'd6); end
        4'd7, 4'd8: begin
          pad_oe   = 1'b0;
          pad_out  = 1'b0;
          feed_en  = 1'b1;
          feed_val = (cfg.stby == 4'd8);
        end
        default: pad_oe = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_out <= 1'b0;
      last_oe  <= 1'b0;
    end else if (!stby_act) begin
      last_out <= norm_out;
      last_oe  <= norm_oe;
    end
  end

  assign term_force = stby_act && (cfg.term != 2'd0);
  assign term_up    = stby_act && (cfg.term == 2'd3);
  assign term_dn    = stby_act && (cfg.term == 2'd2);

  assign core_in = feed_en ? feed_val : (cfg.rxdis ? 1'b0 : s2);
  assign sensed  = feed_en ? (feed_val ^ cfg.rxinv) : (cfg.rxdis ? 1'b0 : (s2 ^ cfg.rxinv));

  assign edge_mode = (cfg.trig == TRIG_ONE) || (cfg.trig == TRIG_BOTH);
  always_comb begin
    case (cfg.trig)
      TRIG_ONE:  set_ev = sensed && !sensed_q;
      TRIG_BOTH: set_ev = sensed ^ sensed_q;
      default:   set_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sensed_q <= 1'b0;
      sts_q    <= 1'b0;
    end else begin
      sensed_q <= sensed;
      if (!edge_mode)  sts_q <= 1'b0;
      else if (set_ev) sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
    end
  end

  assign sts_vis = (cfg.trig == TRIG_LEVEL) ? sensed : sts_q;

  a_r6_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.trig == TRIG_ONE && sensed && !sensed_q) |=> sts_q);
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.trig == TRIG_OFF) |=> !sts_q);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !set_ev) |=> !sts_q);
  a_r4_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rxdis && !feed_en) |-> (!core_in && !sensed));
  a_r10_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_act && (cfg.stby == 4'd7 || cfg.stby == 4'd8 || cfg.stby == 4'd9)) |-> !pad_oe);
endmodule

// File: rtl/gpio_pic.sv
module gpio_pic
  import gpio_pic_pkg::*;
#(
  parameter int NPADS = 8,
  localparam int AW = $clog2(2*NPADS+1)
) (
  input  logic             clk,
  input  logic             rst_pwrok_n,
  input  logic             rst_deep_n,
  input  logic             rst_plt_n,
  input  logic             rst_rsm_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             standby,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe,
  input  logic [NPADS-1:0] nf_out,
  input  logic [NPADS-1:0] nf_oe,
  output logic [NPADS-1:0] core_in,
  output logic [NPADS-1:0] term_force,
  output logic [NPADS-1:0] term_up,
  output logic [NPADS-1:0] term_dn,
  output logic             irq_nmi,
  output logic             irq_smi,
  output logic             irq_sci,
  output logic             irq_apic
);
  localparam int NROUTE = 4;
  localparam logic [AW-1:0] STS_ADDR = AW'(2*NPADS);

  logic [3:0]       dom_rst_n;
  logic [DW-1:0]    w0_q [NPADS];
  logic [DW-1:0]    w1_q [NPADS];
  pad_cfg_t         cfg  [NPADS];
  logic [NPADS-1:0] sts_vis;
  logic             sts_wr;
  logic [NROUTE-1:0] route_or, irq_q;

  assign dom_rst_n = {rst_rsm_n, rst_plt_n, rst_deep_n, rst_pwrok_n};
  assign sts_wr    = reg_wr && (reg_addr == STS_ADDR);

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    gpio_pic_cfg u_cfg (
      .clk(clk), .rst_pwrok_n(rst_pwrok_n), .dom_rst_n(dom_rst_n),
      .we0(reg_wr && reg_addr == AW'(2*i)),
      .we1(reg_wr && reg_addr == AW'(2*i+1)),
      .wdata(reg_wdata), .w0_q(w0_q[i]), .w1_q(w1_q[i]), .cfg(cfg[i])
    );
    gpio_pic_pad u_pad (
      .clk(clk), .rst_n(rst_pwrok_n), .cfg(cfg[i]), .pad_in(pad_in[i]),
      .nf_out(nf_out[i]), .nf_oe(nf_oe[i]), .standby(standby),
      .sts_clr(sts_wr && reg_wdata[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i]), .core_in(core_in[i]),
      .term_force(term_force[i]), .term_up(term_up[i]), .term_dn(term_dn[i]),
      .sts_vis(sts_vis[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STS_ADDR) reg_rdata[NPADS-1:0] = sts_vis;
    for (int i = 0; i < NPADS; i++) begin
      if (reg_addr == AW'(2*i)) begin
        reg_rdata = w0_q[i];
        reg_rdata[W0_RXSEEN] = core_in[i];
      end
      if (reg_addr == AW'(2*i+1)) reg_rdata = w1_q[i];
    end
  end

  always_comb begin
    route_or = '0;
    for (int i = 0; i < NPADS; i++)
      route_or = route_or | ({NROUTE{sts_vis[i]}} & cfg[i].route);
  end

  always_ff @(posedge clk or negedge rst_pwrok_n) begin
    if (!rst_pwrok_n) irq_q <= '0;
    else              irq_q <= route_or;
  end

  assign irq_nmi  = irq_q[0];
  assign irq_smi  = irq_q[1];
  assign irq_sci  = irq_q[2];
  assign irq_apic = irq_q[3];

  a_r9_irq_lags_status: assert property (@(posedge clk) disable iff (!rst_pwrok_n)
    (irq_q != '0) |-> (irq_q == $past(route_or)));
endmodule

// File: tb/gpio_pic_tb.sv
module gpio_pic_tb;
  localparam int NPADS = 8;
  localparam int AW = $clog2(2*NPADS+1);
  localparam logic [31:0] DEF0 = 32'h0400_0100;
  localparam logic [31:0] DEF1 = 32'h0003_C000;
  localparam int STS = 2*NPADS;

  logic clk = 1'b0;
  logic rst_pwrok_n = 1'b0, rst_deep_n = 1'b1, rst_plt_n = 1'b1, rst_rsm_n = 1'b1;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic standby = 1'b0;
  logic [NPADS-1:0] pad_in = '0, pad_out, pad_oe, nf_out = '0, nf_oe = '0, core_in;
  logic [NPADS-1:0] term_force, term_up, term_dn;
  logic irq_nmi, irq_smi, irq_sci, irq_apic;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gpio_pic #(.NPADS(NPADS)) u_dut (
    .clk(clk), .rst_pwrok_n(rst_pwrok_n), .rst_deep_n(rst_deep_n), .rst_plt_n(rst_plt_n),
    .rst_rsm_n(rst_rsm_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .standby(standby), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .nf_out(nf_out), .nf_oe(nf_oe), .core_in(core_in),
    .term_force(term_force), .term_up(term_up), .term_dn(term_dn),
    .irq_nmi(irq_nmi), .irq_smi(irq_smi), .irq_sci(irq_sci), .irq_apic(irq_apic)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [3:0] irqv();
    return {irq_apic, irq_sci, irq_smi, irq_nmi};
  endfunction

  initial begin
    #(20*150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks-fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_pwrok_n = 1'b1;
    tick(2);

    // R1 reset state
    for (int p = 0; p < NPADS; p++) begin
      rd(2*p, d);   chk("R1 word0 default", d, DEF0);
      rd(2*p+1, d); chk("R1 word1 default", d, DEF1);
    end
    rd(STS, d); chk("R1 status default", d, 0);
    chk("R1 oe default", 32'(pad_oe), 0);
    chk("R9 irq default", 32'(irqv()), 0);

    // R1 writable mask
    for (int p = 0; p < NPADS; p++) begin
      wr(2*p, 32'hFFFF_FFFF);   rd(2*p, d);   chk("R1 word0 mask", d, 32'hC69E_1F01);
      wr(2*p+1, 32'hFFFF_FFFF); rd(2*p+1, d); chk("R1 word1 mask", d, 32'h0003_C300);
      wr(2*p, DEF0); wr(2*p+1, DEF1);
    end
    rd(STS, d);
    wr(STS, 32'hFFFF_FFFF);

    // R2 GPIO drive, R3 native modes
    for (int p = 0; p < NPADS; p++) begin
      for (int v = 0; v < 4; v++) begin
        wr(2*p, 32'h0400_0000 | (v & 1) | ((v >> 1) << 8));
        tick(1);
        chk("R2 gpio out", 32'(pad_out[p]), v & 1);
        chk("R2 gpio oe",  32'(pad_oe[p]), ((v >> 1) & 1) ^ 1);
      end
      nf_out[p] = 1'b1; nf_oe[p] = 1'b1;
      for (int m = 1; m < 8; m++) begin
        wr(2*p, 32'h0400_0100 | (m << 10));
        tick(1);
        chk("R3 native out", 32'(pad_out[p]), (m == 7) ? 0 : 1);
        chk("R3 native oe",  32'(pad_oe[p]),  (m == 7) ? 0 : 1);
      end
      nf_out[p] = 1'b0; nf_oe[p] = 1'b0;
      wr(2*p, DEF0);
    end

    // R5 R6 R7 R8 R9 trigger sweep
    for (int p = 0; p < NPADS; p++) begin
      for (int t = 0; t < 4; t++) begin
        for (int inv = 0; inv < 2; inv++) begin
          logic prev, s, sticky, expv;
          int k;
          int seq [5] = '{1, 0, 1, 1, 0};
          k = p % 4;
          pad_in[p] = 1'b0;
          wr(2*p, 32'h0000_0100 | (t << 25) | (inv << 23) | (1 << (17 + k)));
          tick(4);
          wr(STS, 32'hFFFF_FFFF);
          prev = inv[0]; sticky = 1'b0;
          for (int i = 0; i < 5; i++) begin
            pad_in[p] = seq[i][0];
            tick(4);
            s = seq[i][0] ^ inv[0];
            if (t == 1 && !prev && s) sticky = 1'b1;
            if (t == 3 && prev != s) sticky = 1'b1;
            prev = s;
            expv = (t == 0) ? s : (t == 2) ? 1'b0 : sticky;
            rd(STS, d);
            chk(t == 0 ? "R5 level status" : t == 1 ? "R6 single edge" : "R7 both/off", d, 32'(expv) << p);
            chk("R9 routed irq", 32'(irqv()), expv ? (1 << k) : 0);
            if (i == 2) begin
              wr(STS, 32'(1) << p);
              sticky = 1'b0;
              tick(2);
              rd(STS, d);
              chk("R8 clear", d, (t == 0) ? (32'(s) << p) : 0);
            end
          end
        end
      end
      pad_in[p] = 1'b0;
      wr(2*p, DEF0);
    end

    // R4 receiver disabled
    pad_in[1] = 1'b1;
    for (int inv = 0; inv < 2; inv++) begin
      wr(2, 32'h0000_0300 | (inv << 23));
      tick(4);
      rd(STS, d); chk("R4 no event", d, 0);
      rd(2, d);   chk("R4 seen bit", d & 32'h2, 0);
      chk("R4 core_in", 32'(core_in[1]), 0);
    end
    wr(2, DEF0);
    tick(4);
    rd(2, d); chk("R1 seen bit", d & 32'h2, 2);

    // R10 R11 standby sweep on pad 1 (driving 1, input 1, term pull-up)
    wr(2, 32'h0400_0001);
    for (int c = 0; c < 16; c++) begin
      logic eo, ev, ec;
      wr(3, (c << 14) | (3 << 8));
      tick(1);
      standby = 1'b1;
      tick(1);
      case (c)
        1: begin eo = 1; ev = 0; ec = 0; end
        2: begin eo = 1; ev = 0; ec = 1; end
        3: begin eo = 1; ev = 1; ec = 0; end
        4: begin eo = 1; ev = 1; ec = 1; end
        5: begin eo = 1; ev = 0; ec = 1; end
        7: begin eo = 0; ev = 0; ec = 0; end
        8: begin eo = 0; ev = 0; ec = 1; end
        9: begin eo = 0; ev = 0; ec = 1; end
        default: begin eo = 1; ev = 1; ec = 1; end
      endcase
      chk("R10 standby oe", 32'(pad_oe[1]), 32'(eo));
      if (eo) chk("R10 standby out", 32'(pad_out[1]), 32'(ev));
      chk("R10 standby core_in", 32'(core_in[1]), 32'(ec));
      chk("R11 term", {29'd0, term_force[1], term_up[1], term_dn[1]}, (c <= 9) ? 32'h6 : 0);
      standby = 1'b0;
    end
    wr(3, (2 << 14) | (2 << 8));
    standby = 1'b1; tick(1);
    chk("R11 pull-down", {29'd0, term_force[1], term_up[1], term_dn[1]}, 32'h5);
    standby = 1'b0;
    wr(3, (2 << 14) | (1 << 8));
    standby = 1'b1; tick(1);
    chk("R11 no pull", {29'd0, term_force[1], term_up[1], term_dn[1]}, 32'h4);
    standby = 1'b0;
    pad_in[1] = 1'b0;
    wr(2, DEF0); wr(3, DEF1);

    // R12 domain reset
    wr(4, 32'h8400_0101);
    wr(6, 32'h0400_0101);
    wr(5, 32'h0000_0200);
    @(negedge clk); rst_plt_n = 1'b0;
    tick(2); rst_plt_n = 1'b1;
    rd(4, d); chk("R12 selected pad word0", d, DEF0);
    rd(5, d); chk("R12 selected pad word1", d, DEF1);
    rd(6, d); chk("R12 other pad kept", d, 32'h0400_0101);
    @(negedge clk); rst_deep_n = 1'b0;
    tick(2); rst_deep_n = 1'b1;
    rd(6, d); chk("R12 unselected domain ignored", d, 32'h0400_0101);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end
endmodule